// File: doc/BRIEF.md
# Fractional-Increment Master Time Counter

This block keeps a 64-bit time count that advances at a fixed nominal rate, 6.144 MHz, whatever the frequency of the clock that drives it. It does not add one per input clock. On each input clock it adds a programmable numerator to a 12-bit remainder. Whenever the remainder reaches the programmable denominator, the denominator is taken off and the count goes up by one. Over any window of `den` input clocks the count therefore gains exactly `num`. Typical ratios are 8/25 for 19.2 MHz, 4/25 for 38.4 MHz, 384/1625 for 26 MHz and 256/1125 for 27 MHz. The reset ratio is 4/25.

Software sets the ratio through two 32-bit registers. Writing the numerator register changes only a shadow copy. Writing the denominator register arms a reload. On the next input clock, both shadow values move into the active ratio together. On that same clock the remainder is clamped below the new denominator, so no count is lost or doubled.

A control FSM has two states:
- `ST_RUN` accumulates on every clock.
- `ST_HALT` freezes the count and the remainder.

A reload with a valid ratio takes the FSM to `ST_RUN`. A valid ratio is one with `den != 0` and `num < den`. A reload with an invalid ratio takes it to `ST_HALT`. With no reload pending, the state does not change. Any invalid reload also sets a sticky error flag.

Top module: `rtc_master`

## Requirements
- R1: After reset the count is 0 and the error flag is 0. The numerator register reads 0x00000004 and the denominator register reads 0x00000019. The FSM is in `ST_RUN`.
- R2: In `ST_RUN`, each input clock does the following:
  - It adds the active numerator to the remainder.
  - If the sum is at least the active denominator, it subtracts the denominator and raises the count by exactly one.
  - The count never changes by anything other than 0 or +1 in one clock.
- R3: With a stable valid ratio, any run of exactly `den` consecutive clocks raises the count by exactly `num`. This holds for 8/25, 4/25, 384/1625, 256/1125, 64/125 and 768/1625.
- R4: Register map:
  - Offset 0x10 is the numerator register and offset 0x14 is the denominator register.
  - Bits 11:0 of each hold the ratio value.
  - Bits 31:12 are stored as written and read back unchanged.
  - Any other offset reads 0, and writes to it have no effect.
- R5: A numerator write alone does not change the counting rate. A denominator write commits both shadow values on the following clock. That clock already accumulates with the new ratio.
- R6: On a reload, the remainder is first clamped to at most `den-1` of the new ratio. After every accumulating clock, the remainder is below the active denominator.
- R7: A reload with `den == 0` or `num >= den` puts the FSM in `ST_HALT`. In `ST_HALT`, count and remainder hold and the error flag is set. The flag stays set until reset, even after a later valid reload returns the FSM to `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock of whatever frequency the ratio is set for |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| count_o | output | 64 | Free-running time count |
| cfg_err_o | output | 1 | Sticky invalid-ratio flag |

## Verification
The embedded properties check several things on every cycle:
- The count only ever steps by 0 or +1.
- The remainder stays below the denominator after each accumulating clock.
- A denominator write always arms a reload on the next clock.
- The count is frozen in `ST_HALT`.
- The error flag never falls.

Some behaviour only the bench scenarios can show. One is that the count gains exactly `num` per `den` clocks for each listed ratio. Others are that a lone numerator write leaves the rate unchanged, and that upper register bits survive a write. The bench also shows that recovery from an invalid ratio restarts counting while the flag stays set. A behavioural reference model is compared against the count and the flag at every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } rtc_state_e;
endpackage

// File: rtl/rtc_ratio_regs.sv
module rtc_ratio_regs #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int FW = 12,
    parameter logic [AW-1:0] NUM_OFS = 8'h10,
    parameter logic [AW-1:0] DEN_OFS = 8'h14,
    parameter int RST_NUM = 4,
    parameter int RST_DEN = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data_o,
    output logic          commit_o,
    output logic [FW-1:0] nxt_num_o,
    output logic [FW-1:0] nxt_den_o
);
    localparam int HW = DW - FW;

    logic [HW-1:0] num_hi_q, den_hi_q;
    logic [FW-1:0] num_sh_q, den_sh_q;
    logic [FW-1:0] num_act_q, den_act_q;
    logic          pend_q;
    logic          hit_num, hit_den;

    assign hit_num = wr_en && (wr_addr == NUM_OFS);
    assign hit_den = wr_en && (wr_addr == DEN_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_hi_q  <= '0;
            den_hi_q  <= '0;
            num_sh_q  <= FW'(RST_NUM);
            den_sh_q  <= FW'(RST_DEN);
            num_act_q <= FW'(RST_NUM);
            den_act_q <= FW'(RST_DEN);
            pend_q    <= 1'b0;
        end else begin
            if (pend_q) begin
                num_act_q <= num_sh_q;
                den_act_q <= den_sh_q;
            end
            if (hit_num) begin
                num_hi_q <= wr_data[DW-1:FW];
                num_sh_q <= wr_data[FW-1:0];
            end
            if (hit_den) begin
                den_hi_q <= wr_data[DW-1:FW];
                den_sh_q <= wr_data[FW-1:0];
            end
            pend_q <= hit_den;
        end
    end

    assign commit_o  = pend_q;
    assign nxt_num_o = pend_q ? num_sh_q : num_act_q;
    assign nxt_den_o = pend_q ? den_sh_q : den_act_q;

    always_comb begin
        if (rd_addr == NUM_OFS)      rd_data_o = {num_hi_q, num_sh_q};
        else if (rd_addr == DEN_OFS) rd_data_o = {den_hi_q, den_sh_q};
        else                         rd_data_o = '0;
    end

    // R5: a denominator write always arms a reload on the next clock
    p_reload_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_den |=> commit_o);
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [FW-1:0] num_i,
    input  logic [FW-1:0] den_i,
    output logic          carry_o
);
    logic [FW-1:0] rem_q, base;
    logic [FW:0]   sum, diff;

    always_comb begin
        base    = (rem_q >= den_i) ? (den_i - FW'(1)) : rem_q;
        sum     = {1'b0, base} + {1'b0, num_i};
        diff    = sum - {1'b0, den_i};
        carry_o = step_i && (sum >= {1'b0, den_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rem_q <= '0;
        else if (step_i)  rem_q <= carry_o ? diff[FW-1:0] : sum[FW-1:0];
    end

    // R6: remainder stays below the denominator it was stepped with
    p_rem_below_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (rem_q < $past(den_i)));
endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    output logic [CW-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count_o <= '0;
        else if (inc_i) count_o <= count_o + CW'(1);
    end

    // R2: the count moves by 0 or +1 per clock
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CW'(1)));
endmodule

// File: rtl/rtc_master.sv
module rtc_master #(
    parameter int CW      = 64,
    parameter int FW      = 12,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int RST_NUM = 4,
    parameter int RST_DEN = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count_o,
    output logic          cfg_err_o
);
    import rtc_pkg::*;

    rtc_state_e    state_q, state_n;
    logic          commit, ratio_ok, step_en, carry, err_n;
    logic [FW-1:0] nxt_num, nxt_den;

    rtc_ratio_regs #(
        .AW(AW), .DW(DW), .FW(FW),
        .NUM_OFS(AW'(8'h10)), .DEN_OFS(AW'(8'h14)),
        .RST_NUM(RST_NUM), .RST_DEN(RST_DEN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data_o(rd_data),
        .commit_o(commit), .nxt_num_o(nxt_num), .nxt_den_o(nxt_den)
    );

    rtc_frac_accum #(.FW(FW)) u_accum (
        .clk(clk), .rst_n(rst_n), .step_i(step_en),
        .num_i(nxt_num), .den_i(nxt_den), .carry_o(carry)
    );

    rtc_count #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .inc_i(carry), .count_o(count_o)
    );

    assign ratio_ok = (nxt_den != '0) && (nxt_num < nxt_den);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            cfg_err_o <= 1'b0;
        end else begin
            state_q   <= state_n;
            cfg_err_o <= err_n;
        end
    end

    always_comb begin
        state_n = state_q;
        err_n   = cfg_err_o;
        step_en = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (commit && !ratio_ok) begin
                    state_n = ST_HALT;
                    err_n   = 1'b1;
                end else begin
                    step_en = 1'b1;
                end
            end
            ST_HALT: begin
                if (commit && ratio_ok) begin
                    state_n = ST_RUN;
                    step_en = 1'b1;
                end else if (commit) begin
                    err_n = 1'b1;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    // R7: count frozen while halted with no reload
    p_hold_in_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !commit) |=> $stable(count_o));
    // R7: error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
endmodule

// File: tb/tb_rtc_master.sv
module tb_rtc_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] count_o;
    logic        cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;

    rtc_master dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count_o(count_o), .cfg_err_o(cfg_err_o)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_shn, m_shd;
    int          m_an, m_ad, m_rem, m_r, m_s;
    logic [63:0] m_cnt;
    bit          m_pend, m_halt, m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_shn = 32'd4; m_shd = 32'd25; m_an = 4; m_ad = 25;
            m_rem = 0; m_cnt = '0; m_pend = 0; m_halt = 0; m_err = 0;
        end else begin
            if (m_pend) begin
                m_an = int'(m_shn[11:0]);
                m_ad = int'(m_shd[11:0]);
                if (m_ad == 0 || m_an >= m_ad) begin
                    m_halt = 1; m_err = 1;
                end else begin
                    m_halt = 0;
                end
            end
            if (!m_halt) begin
                m_r = (m_rem >= m_ad) ? m_ad - 1 : m_rem;
                m_s = m_r + m_an;
                if (m_s >= m_ad) begin
                    m_rem = m_s - m_ad;
                    m_cnt = m_cnt + 64'd1;
                end else begin
                    m_rem = m_s;
                end
            end
            m_pend = wr_en && (wr_addr == 8'h14);
            if (wr_en && wr_addr == 8'h10) m_shn = wr_data;
            if (wr_en && wr_addr == 8'h14) m_shd = wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(count_o == m_cnt, "R2 count", count_o, m_cnt);
            check(cfg_err_o == m_err, "R7 err", {63'd0, cfg_err_o}, {63'd0, m_err});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ratio(input int num, input int den);
        wr(8'h10, 32'h5A5A5000 | 32'(num));
        wr(8'h14, 32'hA5A5A000 | 32'(den));
        @(negedge clk);
    endtask

    task automatic ratio_run(input int num, input int den, input string req);
        logic [63:0] c0;
        c0 = count_o;
        repeat (den) @(negedge clk);
        check(count_o - c0 == 64'(num), req, count_o - c0, 64'(num));
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_addr = 8'h10; #1;
        check(rd_data == 32'h4, "R1 num reg", {32'd0, rd_data}, 64'h4);
        rd_addr = 8'h14; #1;
        check(rd_data == 32'h19, "R1 den reg", {32'd0, rd_data}, 64'h19);
        check(count_o == 0 && !cfg_err_o, "R1 count/err", count_o, 64'd0);
        // R3 default ratio
        ratio_run(4, 25, "R3 4/25 default");
        // R4 readback with upper bits
        set_ratio(8, 25);
        rd_addr = 8'h10; #1;
        check(rd_data == 32'h5A5A5008, "R4 num upper", {32'd0, rd_data}, 64'h5A5A5008);
        rd_addr = 8'h14; #1;
        check(rd_data == 32'hA5A5A019, "R4 den upper", {32'd0, rd_data}, 64'hA5A5A019);
        ratio_run(8, 25, "R3 8/25");
        // R4 unused offset
        wr(8'h18, 32'hFFFFFFFF);
        rd_addr = 8'h18; #1;
        check(rd_data == 0, "R4 unused read", {32'd0, rd_data}, 64'd0);
        ratio_run(8, 25, "R4 unused write ignored");
        // R5 numerator alone has no effect
        wr(8'h10, 32'd1);
        @(negedge clk);
        ratio_run(8, 25, "R5 num-only write");
        wr(8'h14, 32'd25);
        @(negedge clk);
        ratio_run(1, 25, "R5 reload commits num");
        foreach (RATIOS_N[i]) begin
            set_ratio(RATIOS_N[i], RATIOS_D[i]);
            ratio_run(RATIOS_N[i], RATIOS_D[i], "R3 listed ratio");
        end
        // R6 clamp on shrink after large remainder
        set_ratio(1, 3);
        ratio_run(1, 3, "R6 clamp then 1/3");
        // R7 invalid den zero
        set_ratio(0, 0);
        c0 = count_o;
        repeat (40) @(negedge clk);
        check(count_o == c0 && cfg_err_o, "R7 den zero hold", count_o, c0);
        set_ratio(5, 3);
        c0 = count_o;
        repeat (40) @(negedge clk);
        check(count_o == c0, "R7 num>=den hold", count_o, c0);
        set_ratio(4, 25);
        ratio_run(4, 25, "R7 recover");
        check(cfg_err_o == 1'b1, "R7 sticky", {63'd0, cfg_err_o}, 64'd1);
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int RATIOS_N[6] = '{8, 4, 384, 256, 64, 768};
    int RATIOS_D[6] = '{25, 25, 1625, 1125, 125, 1625};
endmodule